// File: doc/BRIEF.md
# In-Order Multi-Retire Reorder Buffer

This block keeps the instructions a core has issued in program order and frees them in that same order. It is a circular queue of slots. A dispatch request claims one to four slots at the tail in a single cycle and gets back the tag of the first one. The other tags follow on in sequence, modulo the depth. Execution units report completion by tag on a finish port, and that report may carry an exception mark.

Each cycle the retire logic inspects the four oldest slots. It frees the longest run, starting at the oldest, of slots that are finished and carry no exception mark. A finished slot that carries an exception mark is never freed. Instead it is reported, and it and every younger slot are discarded, which keeps exceptions precise. A branch-resolution port reports a misprediction by tag. That flushes every slot younger than the branch while keeping the branch and everything older.

The head and tail pointers each carry one wrap bit beyond the tag. A full buffer and an empty buffer therefore differ even though their tags are equal.

Top module: `reorder_buf`

## Requirements
- R1: After reset the buffer is empty: the next dispatch tag is 0, the oldest tag is 0, the retire count is 0, there is no exception report, and a request for four slots does not stall.
- R2: A dispatch of N slots (N from 0 to 4) that is not stalled claims tags T, T+1, ... T+N-1 modulo 16, where T is the current dispatch tag. The dispatch tag reads T+N modulo 16 from the next cycle.
- R3: The buffer holds at most 16 slots. The stall output is high when the requested count exceeds the free slots, or in any cycle with a flush. A stalled request claims nothing, and the dispatch tag stays the same.
- R4: A slot retires only when it is finished and every older slot retires in the same cycle or has already retired. A slot finished at one clock edge is counted in the retire count in the cycle right after that edge and is freed at the next edge.
- R5: At most 4 slots retire per cycle, even when more are finished.
- R6: Retirement is in program order. The oldest tag is the tag of the first slot being retired, and it advances by the retire count at each edge.
- R7: A misprediction reported for the slot at tag B discards every younger slot, and the dispatch tag reads B+1 in the next cycle. A finish report for a slot that is not occupied is ignored, and a newly dispatched slot always starts unfinished and without an exception mark.
- R8: Retirement stops at the first finished slot that carries an exception mark. That slot's tag appears on the exception output while the older slots in the window still retire. At the next edge the marked slot and all younger slots are discarded, the buffer is empty, and the dispatch tag equals the marked slot's tag.
- R9: When a misprediction and an exception arise in the same cycle, the cut that lies closer to the oldest slot wins. Slots younger than a reported branch neither retire nor raise an exception report in that cycle.
- R10: Tags and pointers wrap modulo 16. Sixteen slots can be held at once, and the buffer still counts as full, not empty, when the dispatch tag wraps around to equal the oldest tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_num_i | input | 3 | Number of slots requested this cycle (0..4) |
| disp_stall_o | output | 1 | Request refused this cycle |
| disp_tag_o | output | 4 | Tag of the first slot a dispatch would claim |
| fin_vld_i | input | 1 | Finish report valid |
| fin_tag_i | input | 4 | Tag of the finished slot |
| fin_exc_i | input | 1 | Finished slot raised an exception |
| br_mis_i | input | 1 | Mispredicted branch reported |
| br_tag_i | input | 4 | Tag of the mispredicted branch |
| ret_cnt_o | output | 3 | Slots retiring at the coming edge (0..4) |
| ret_tag_o | output | 4 | Tag of the oldest slot |
| exc_vld_o | output | 1 | Oldest unretired slot in the window holds an exception |
| exc_tag_o | output | 4 | Tag of that slot |

## Verification
The stall, the retire count, the oldest tag and the exception report come combinationally from the registered state and the current inputs, so each is due in the same cycle as the request that drives it. A finish report takes effect at the next edge, so the retire count it enables shows up one cycle later, and the freed slots leave at the edge after that. A dispatch or a flush shows on the dispatch tag one edge after it is requested. The bench drives every input just after a falling edge and reads the outputs 1 ns later, well before the next rising edge. Each check therefore falls in the cycle these latencies predict.

// File: rtl/rob_pkg.sv
package rob_pkg;

    // Per-slot bookkeeping kept by the reorder buffer.
    typedef struct packed {
        logic valid;   // slot occupied
        logic done;    // execution finished
        logic exc;     // finished with an exception
    } rob_ent_t;

endpackage

// File: rtl/rob_br_window.sv
// Turns a branch tag into the number of slots that survive a misprediction,
// and bounds the retire window to those survivors.
module rob_br_window #(
    parameter int DEPTH  = 16,
    localparam int TAG_W = $clog2(DEPTH),
    localparam int PTR_W = TAG_W + 1
) (
    input  logic             br_mis_i,
    input  logic [TAG_W-1:0] br_tag_i,
    input  logic [TAG_W-1:0] head_tag_i,
    input  logic [PTR_W-1:0] occ_i,
    output logic [PTR_W-1:0] br_keep_o,
    output logic [PTR_W-1:0] limit_o
);

    logic [TAG_W-1:0] br_age;

    assign br_age    = br_tag_i - head_tag_i;
    assign br_keep_o = {1'b0, br_age} + PTR_W'(1);
    assign limit_o   = br_mis_i ? br_keep_o : occ_i;

endmodule

// File: rtl/rob_retire_scan.sv
// Scans the oldest RET_W slots and counts the in-order run that may retire;
// flags a finished slot with an exception that ends the run.
module rob_retire_scan #(
    parameter int DEPTH   = 16,
    parameter int RET_W   = 4,
    localparam int TAG_W  = $clog2(DEPTH),
    localparam int PTR_W  = TAG_W + 1,
    localparam int RCNT_W = $clog2(RET_W + 1)
) (
    input  logic [TAG_W-1:0]  head_tag_i,
    input  logic [PTR_W-1:0]  limit_i,
    input  logic [DEPTH-1:0]  valid_i,
    input  logic [DEPTH-1:0]  done_i,
    input  logic [DEPTH-1:0]  exc_i,
    output logic [RCNT_W-1:0] ret_cnt_o,
    output logic              exc_hit_o
);

    logic             run;
    logic [TAG_W-1:0] idx;

    always_comb begin
        run       = 1'b1;
        ret_cnt_o = '0;
        exc_hit_o = 1'b0;
        idx       = head_tag_i;
        for (int i = 0; i < RET_W; i++) begin
            idx = head_tag_i + TAG_W'(i);
            if (run && (PTR_W'(i) < limit_i) && valid_i[idx] && done_i[idx]) begin
                if (exc_i[idx]) begin
                    exc_hit_o = 1'b1;
                    run       = 1'b0;
                end else begin
                    ret_cnt_o = ret_cnt_o + RCNT_W'(1);
                end
            end else begin
                run = 1'b0;
            end
        end
    end

endmodule

// File: rtl/reorder_buf.sv
module reorder_buf #(
    parameter int DEPTH   = 16,
    parameter int DISP_W  = 4,
    parameter int RET_W   = 4,
    localparam int TAG_W  = $clog2(DEPTH),
    localparam int PTR_W  = TAG_W + 1,
    localparam int CNT_W  = $clog2(DISP_W + 1),
    localparam int RCNT_W = $clog2(RET_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  disp_num_i,
    output logic              disp_stall_o,
    output logic [TAG_W-1:0]  disp_tag_o,
    input  logic              fin_vld_i,
    input  logic [TAG_W-1:0]  fin_tag_i,
    input  logic              fin_exc_i,
    input  logic              br_mis_i,
    input  logic [TAG_W-1:0]  br_tag_i,
    output logic [RCNT_W-1:0] ret_cnt_o,
    output logic [TAG_W-1:0]  ret_tag_o,
    output logic              exc_vld_o,
    output logic [TAG_W-1:0]  exc_tag_o
);
    import rob_pkg::*;

    // DEPTH must be a power of two: tags wrap by truncation.
    typedef struct packed {
        logic [PTR_W-1:0]           head;
        logic [PTR_W-1:0]           tail;
        rob_ent_t [DEPTH-1:0]       ents;
    } state_t;

    state_t st_d, st_q;

    logic [TAG_W-1:0]  head_tag, tail_tag;
    logic [PTR_W-1:0]  occ, free_slots, br_keep, limit, cut;
    logic [DEPTH-1:0]  valid_vec, done_vec, exc_vec;
    logic              exc_hit, flush;
    logic [RCNT_W-1:0] ret_cnt;

    assign head_tag   = st_q.head[TAG_W-1:0];
    assign tail_tag   = st_q.tail[TAG_W-1:0];
    assign occ        = st_q.tail - st_q.head;
    assign free_slots = PTR_W'(DEPTH) - occ;

    for (genvar j = 0; j < DEPTH; j++) begin : g_vec
        assign valid_vec[j] = st_q.ents[j].valid;
        assign done_vec[j]  = st_q.ents[j].done;
        assign exc_vec[j]   = st_q.ents[j].exc;
    end

    rob_br_window #(.DEPTH(DEPTH)) u_win (
        .br_mis_i   (br_mis_i),
        .br_tag_i   (br_tag_i),
        .head_tag_i (head_tag),
        .occ_i      (occ),
        .br_keep_o  (br_keep),
        .limit_o    (limit)
    );

    rob_retire_scan #(.DEPTH(DEPTH), .RET_W(RET_W)) u_scan (
        .head_tag_i (head_tag),
        .limit_i    (limit),
        .valid_i    (valid_vec),
        .done_i     (done_vec),
        .exc_i      (exc_vec),
        .ret_cnt_o  (ret_cnt),
        .exc_hit_o  (exc_hit)
    );

    // An exception found inside the window is never younger than the branch.
    assign flush = exc_hit | br_mis_i;
    assign cut   = exc_hit ? PTR_W'(ret_cnt) : br_keep;

    assign disp_stall_o = flush || (PTR_W'(disp_num_i) > free_slots);
    assign disp_tag_o   = tail_tag;
    assign ret_cnt_o    = ret_cnt;
    assign ret_tag_o    = head_tag;
    assign exc_vld_o    = exc_hit;
    assign exc_tag_o    = head_tag + TAG_W'(ret_cnt);

    always_comb begin
        logic [TAG_W-1:0] slot;
        logic [TAG_W-1:0] age;
        st_d = st_q;
        slot = '0;
        age  = '0;

        // completion report for an occupied slot
        if (fin_vld_i && st_q.ents[fin_tag_i].valid) begin
            st_d.ents[fin_tag_i].done = 1'b1;
            st_d.ents[fin_tag_i].exc  = fin_exc_i;
        end

        // release retiring slots
        for (int i = 0; i < RET_W; i++) begin
            if (RCNT_W'(i) < ret_cnt) begin
                slot = head_tag + TAG_W'(i);
                st_d.ents[slot] = '0;
            end
        end
        st_d.head = st_q.head + PTR_W'(ret_cnt);

        if (flush) begin
            st_d.tail = st_q.head + cut;
            for (int j = 0; j < DEPTH; j++) begin
                age = TAG_W'(j) - head_tag;
                if ((PTR_W'(age) >= cut) && (PTR_W'(age) < occ)) begin
                    st_d.ents[j] = '0;
                end
            end
        end else if (!disp_stall_o) begin
            for (int i = 0; i < DISP_W; i++) begin
                if (CNT_W'(i) < disp_num_i) begin
                    slot = tail_tag + TAG_W'(i);
                    st_d.ents[slot] = '{valid: 1'b1, done: 1'b0, exc: 1'b0};
                end
            end
            st_d.tail = st_q.tail + PTR_W'(disp_num_i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= PTR_W'(DEPTH)); // R3

    AST_STALL_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_stall_o && !flush) |=> (disp_tag_o == $past(disp_tag_o))); // R3

    AST_RET_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        ret_cnt_o <= RCNT_W'(RET_W)); // R5

    AST_RET_WITHIN_OCC: assert property (@(posedge clk) disable iff (!rst_n)
        PTR_W'(ret_cnt_o) <= occ); // R4

    AST_HEAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ret_tag_o == $past(ret_tag_o) + TAG_W'($past(ret_cnt_o)))); // R6

    AST_EXC_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        exc_vld_o |=> (disp_tag_o == $past(exc_tag_o) && ret_tag_o == disp_tag_o)); // R8

    AST_BR_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (br_mis_i && !exc_vld_o) |=> (disp_tag_o == $past(br_tag_i) + TAG_W'(1))); // R7

endmodule

// File: tb/tb_reorder_buf.sv
module tb_reorder_buf;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] disp_num;
    logic       disp_stall;
    logic [3:0] disp_tag;
    logic       fin_vld;
    logic [3:0] fin_tag;
    logic       fin_exc;
    logic       br_mis;
    logic [3:0] br_tag;
    logic [2:0] ret_cnt;
    logic [3:0] ret_tag;
    logic       exc_vld;
    logic [3:0] exc_tag;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  finished = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    reorder_buf dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .disp_num_i   (disp_num),
        .disp_stall_o (disp_stall),
        .disp_tag_o   (disp_tag),
        .fin_vld_i    (fin_vld),
        .fin_tag_i    (fin_tag),
        .fin_exc_i    (fin_exc),
        .br_mis_i     (br_mis),
        .br_tag_i     (br_tag),
        .ret_cnt_o    (ret_cnt),
        .ret_tag_o    (ret_tag),
        .exc_vld_o    (exc_vld),
        .exc_tag_o    (exc_tag)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle();
        disp_num = 0; fin_vld = 0; fin_tag = 0; fin_exc = 0; br_mis = 0; br_tag = 0;
    endtask

    // advance to the next falling edge, then let the caller drive
    task automatic step();
        @(negedge clk);
        idle();
    endtask

    task automatic fin(input int tag, input bit exc);
        fin_vld = 1; fin_tag = 4'(tag); fin_exc = exc;
        step();
    endtask

    task automatic t_reset();
        disp_num = 4; #1;
        chk("R1", "disp_tag", disp_tag, 0);
        chk("R1", "ret_tag", ret_tag, 0);
        chk("R1", "ret_cnt", ret_cnt, 0);
        chk("R1", "exc_vld", exc_vld, 0);
        chk("R1", "stall", disp_stall, 0);
        disp_num = 0;
    endtask

    task automatic t_inorder();
        disp_num = 4; #1; chk("R2", "stall", disp_stall, 0); step();
        #1; chk("R2", "disp_tag after 4", disp_tag, 4);
        fin(2, 0);
        fin(0, 0);
        #1; chk("R4", "ret_cnt with gap at 1", ret_cnt, 1);
        chk("R6", "ret_tag", ret_tag, 0);
        step();
        #1; chk("R4", "ret_cnt waits for 1", ret_cnt, 0);
        chk("R6", "ret_tag advanced", ret_tag, 1);
        fin(1, 0);
        #1; chk("R4", "ret_cnt run 1..2", ret_cnt, 2);
        step();
        fin(3, 0);
        #1; chk("R6", "ret_tag", ret_tag, 3);
        chk("R4", "ret_cnt last", ret_cnt, 1);
        step();
    endtask

    task automatic t_full_burst();
        // head = tail = tag 4
        for (int k = 0; k < 3; k++) begin disp_num = 4; step(); end
        disp_num = 3; step();
        disp_num = 4; #1; chk("R3", "stall free 1 ask 4", disp_stall, 1); step();
        #1; chk("R3", "no alloc when stalled", disp_tag, 3);
        disp_num = 1; #1; chk("R3", "ask 1 of 1 free", disp_stall, 0); step();
        disp_num = 1; #1; chk("R10", "full stalls", disp_stall, 1);
        chk("R10", "tag wrapped to head", disp_tag, ret_tag);
        step();
        for (int k = 0; k < 15; k++) fin((3 - k) & 15, 0);
        #1; chk("R4", "oldest unfinished blocks", ret_cnt, 0);
        fin(4, 0);
        for (int k = 0; k < 4; k++) begin
            #1; chk("R5", "burst ret_cnt", ret_cnt, 4);
            chk("R6", "burst ret_tag", ret_tag, (4 + 4 * k) & 15);
            step();
        end
        disp_num = 4; #1; chk("R10", "empty after wrap", disp_stall, 0);
        chk("R10", "ret_cnt empty", ret_cnt, 0);
        disp_num = 0;
    endtask

    task automatic t_branch();
        // head = tail = tag 4
        disp_num = 4; step();
        br_mis = 1; br_tag = 5; disp_num = 2;
        #1; chk("R3", "stall during flush", disp_stall, 1);
        step();
        #1; chk("R7", "disp_tag after flush", disp_tag, 6);
        fin(7, 0);                 // slot 7 was discarded: ignored
        disp_num = 2; step();      // new 6,7
        fin(6, 0);
        fin(5, 0);
        fin(4, 0);
        #1; chk("R7", "stale finish ignored", ret_cnt, 3);
        chk("R6", "ret_tag", ret_tag, 4);
        step();
        fin(7, 0);
        #1; chk("R7", "new slot 7 retires", ret_cnt, 1);
        chk("R7", "ret_tag 7", ret_tag, 7);
        step();
    endtask

    task automatic t_exception();
        // head = tail = tag 8
        disp_num = 4; step();      // 8..11
        fin(9, 1);
        fin_vld = 1; fin_tag = 10; #1;
        chk("R8", "no report before older finish", exc_vld, 0);
        step();
        fin(8, 0);
        disp_num = 1; #1;
        chk("R8", "older retires", ret_cnt, 1);
        chk("R8", "exc_vld", exc_vld, 1);
        chk("R8", "exc_tag", exc_tag, 9);
        chk("R3", "stall on exception", disp_stall, 1);
        step();
        #1; chk("R8", "disp_tag = exc tag", disp_tag, 9);
        chk("R8", "empty ret_tag", ret_tag, 9);
        chk("R8", "report cleared", exc_vld, 0);
        disp_num = 1; step();      // new 9
        fin(9, 0);
        #1; chk("R7", "redispatch clears mark", ret_cnt, 1);
        chk("R7", "no exception", exc_vld, 0);
        step();
    endtask

    task automatic t_race();
        // head = tail = tag 10
        disp_num = 4; step();      // 10..13
        fin(12, 1);
        fin(11, 0);
        fin(10, 0);
        br_mis = 1; br_tag = 10; #1;
        chk("R9", "only branch retires", ret_cnt, 1);
        chk("R9", "younger exception hidden", exc_vld, 0);
        step();
        #1; chk("R9", "branch cut", disp_tag, 11);
        chk("R9", "ret_tag", ret_tag, 11);
        disp_num = 4; step();      // 11..14
        fin(12, 1);
        fin(11, 0);
        br_mis = 1; br_tag = 13; #1;
        chk("R9", "retire before exc", ret_cnt, 1);
        chk("R9", "exc reported", exc_vld, 1);
        chk("R9", "exc_tag", exc_tag, 12);
        step();
        #1; chk("R9", "exception cut wins", disp_tag, 12);
        chk("R9", "empty", ret_tag, 12);
    endtask

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_inorder();
        t_full_burst();
        t_branch();
        t_exception();
        t_race();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule